// File: doc/BRIEF.md
# SDRAM Low-Power Mode Sequencer

This block sits beside a DDR or mobile SDRAM controller and decides when the memory device drops into a low-power state. A 2-bit mode code chooses the state: off, self refresh, power-down or deep power-down. Two further settings control it: a clock-freeze enable for power-down, and a partial-array refresh value. Whenever the controller is idle and initialization is complete, the block issues the entry command and pulls CKE low. When an access request arrives, it brings the device back out and returns a grant. Once the access completes, it drops the device back into the chosen state.

The block works against a small command port (valid, code, data), the CKE pin and a memory clock enable. The exit latency is counted in clock cycles and is programmable. Before self refresh, if the partial-array value differs from the one last written to the device, the block first writes the extended mode register. Deep power-down is left only through a separate wake request, and leaving it asks for re-initialization.

States: AWAKE (idle, device up), EMR_WR (extended mode register write), ENTER (entry command), ASLEEP (self refresh or power-down), EXIT (exit latency count), ACCESS (granted, waiting for completion), DEEP (deep power-down) and WAKE (leaving deep power-down). Transitions:
- AWAKE→ACCESS on a request.
- AWAKE→EMR_WR or AWAKE→ENTER when initialized and the mode is not off.
- EMR_WR→ENTER.
- ENTER→ASLEEP, or ENTER→DEEP for mode 3.
- ASLEEP→EXIT on a request.
- EXIT→ACCESS when the count ends.
- ACCESS→AWAKE on access done.
- DEEP→WAKE on a wake request.
- WAKE→AWAKE when the count ends.

Top module: `sdram_lp_seq`

## Requirements
- R1: Reset state: the design idles awake, with cke=1, clk_en=1, cmd_valid=0, acc_gnt=0, acc_err=0 and reinit_req=0.
- R2: With mode 0 (off), no command is ever issued and cke stays 1. A request made while the device is awake is granted in the same cycle.
- R3: With mode 1 (self refresh), initialization done and no request pending, the entry command is issued in the cycle after the block leaves AWAKE. Entry is code 1, or code 5 first when R7 applies. In the sleeping state that follows, cke=0 and clk_en=0.
- R4: With mode 2 (power-down), the entry command is code 2, one cycle after leaving AWAKE. While asleep, cke=0 and clk_en equals the inverse of the clock-freeze bit.
- R5: A request arriving while asleep starts the exit. In the first exit cycle the block issues code 4 with cke=1. acc_gnt rises exactly exit_lat+1 cycles after the cycle in which the request is first seen.
- R6: After a one-cycle acc_done pulse, the block returns to AWAKE and issues the entry command again. That command appears two cycles after the pulse starts.
- R7: Before a self-refresh entry, if cfg_pasr differs from the value last written, code 5 is issued with cmd_data equal to cfg_pasr, followed in the next cycle by code 1. No code 5 is issued when the value is unchanged or for power-down entry. The recorded value resets to 0.
- R8: With mode 3, code 3 is issued, after which cke=0 and clk_en=0. A request in deep power-down raises acc_err and is never granted.
- R9: A wake_req in deep power-down issues code 4 in the first wake cycle with cke=1. reinit_req pulses exit_lat+1 cycles after the cycle in which wake_req is first seen, and the block then returns to AWAKE. The recorded partial-array value returns to 0.
- R10: A change to cfg_mode while the device is asleep or exiting is not applied until the block is back in AWAKE.
- R11: While init_done is 0, no entry command is issued and cke stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Low-power mode: 0 off, 1 self refresh, 2 power-down, 3 deep power-down |
| cfg_clk_freeze | input | 1 | Hold memory clock low in power-down |
| cfg_pasr | input | PASR_W | Partial-array refresh value |
| cfg_exit_lat | input | LAT_W | Exit latency in cycles |
| init_done | input | 1 | Device initialization complete |
| acc_req | input | 1 | Access request, held until granted |
| acc_done | input | 1 | Access complete pulse |
| wake_req | input | 1 | Leave deep power-down |
| acc_gnt | output | 1 | Access granted |
| acc_err | output | 1 | Request refused in deep power-down |
| cmd_valid | output | 1 | Command strobe |
| cmd_code | output | 3 | 1 self refresh, 2 power-down, 3 deep, 4 exit, 5 extended mode write |
| cmd_data | output | PASR_W | Partial-array value for code 5 |
| cke | output | 1 | Clock-enable pin to the device |
| clk_en | output | 1 | Memory clock enable |
| reinit_req | output | 1 | Pulse: device needs re-initialization |

## Verification
Mode codes 1 and 2 are swept against both clock-freeze values and four exit latencies. This separates power-down with the clock running from power-down with the clock frozen and from self refresh, and checks the grant delay against each latency. The partial-array value changes across the sweep in some runs and repeats in others, so a missed or needless extended-mode write shows up. Separate passes cover mode 0, a held-off initialization, a mode change made while asleep, and deep power-down with a refused access followed by a wake.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;

    typedef enum logic [1:0] {
        LPM_OFF   = 2'd0,
        LPM_SREF  = 2'd1,
        LPM_PDOWN = 2'd2,
        LPM_DEEP  = 2'd3
    } lp_mode_e;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_SREF  = 3'd1,
        CMD_PDOWN = 3'd2,
        CMD_DEEP  = 3'd3,
        CMD_EXIT  = 3'd4,
        CMD_EMR   = 3'd5
    } lp_cmd_e;

    typedef enum logic [2:0] {
        ST_AWAKE,
        ST_EMR_WR,
        ST_ENTER,
        ST_ASLEEP,
        ST_EXIT,
        ST_ACCESS,
        ST_DEEP,
        ST_WAKE
    } lp_state_e;

endpackage

// File: rtl/lp_exit_timer.sv
module lp_exit_timer #(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LAT_W-1:0] lat,
    output logic             first,
    output logic             done
);
    logic [LAT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= '0;
        else if (cnt != lat)
            cnt <= cnt + 1'b1;
    end

    assign first = (cnt == '0);
    assign done  = (cnt == lat);
endmodule

// File: rtl/lp_pasr_track.sv
module lp_pasr_track #(
    parameter int PASR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PASR_W-1:0] wr_val,
    input  logic              clear,
    input  logic [PASR_W-1:0] cur_val,
    output logic              dirty
);
    logic [PASR_W-1:0] last_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            last_val <= '0;
        else if (clear)
            last_val <= '0;
        else if (wr_en)
            last_val <= wr_val;
    end

    assign dirty = (cur_val != last_val);
endmodule

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq
    import sdram_lp_pkg::*;
#(
    parameter int PASR_W = 3,
    parameter int LAT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_clk_freeze,
    input  logic [PASR_W-1:0] cfg_pasr,
    input  logic [LAT_W-1:0]  cfg_exit_lat,
    input  logic              init_done,
    input  logic              acc_req,
    input  logic              acc_done,
    input  logic              wake_req,
    output logic              acc_gnt,
    output logic              acc_err,
    output logic              cmd_valid,
    output logic [2:0]        cmd_code,
    output logic [PASR_W-1:0] cmd_data,
    output logic              cke,
    output logic              clk_en,
    output logic              reinit_req
);
    lp_state_e         state, state_nx;
    lp_mode_e          act_mode;
    logic              act_freeze;
    logic [PASR_W-1:0] act_pasr;
    logic              tmr_start, tmr_first, tmr_done;
    logic              pasr_dirty;
    lp_cmd_e           cmd_e;

    assign tmr_start = (state_nx != state) &&
                       (state_nx == ST_EXIT || state_nx == ST_WAKE);

    lp_exit_timer #(.LAT_W(LAT_W)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .lat   (cfg_exit_lat),
        .first (tmr_first),
        .done  (tmr_done)
    );

    lp_pasr_track #(.PASR_W(PASR_W)) i_pasr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (state == ST_EMR_WR),
        .wr_val  (act_pasr),
        .clear   (reinit_req),
        .cur_val (cfg_pasr),
        .dirty   (pasr_dirty)
    );

    // state register and settings latched only while awake
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_AWAKE;
            act_mode   <= LPM_OFF;
            act_freeze <= 1'b0;
            act_pasr   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_AWAKE) begin
                act_mode   <= lp_mode_e'(cfg_mode);
                act_freeze <= cfg_clk_freeze;
                act_pasr   <= cfg_pasr;
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_AWAKE: begin
                if (acc_req)
                    state_nx = ST_ACCESS;
                else if (init_done && lp_mode_e'(cfg_mode) != LPM_OFF) begin
                    if (lp_mode_e'(cfg_mode) == LPM_SREF && pasr_dirty)
                        state_nx = ST_EMR_WR;
                    else
                        state_nx = ST_ENTER;
                end
            end
            ST_EMR_WR: state_nx = ST_ENTER;
            ST_ENTER:  state_nx = (act_mode == LPM_DEEP) ? ST_DEEP : ST_ASLEEP;
            ST_ASLEEP: if (acc_req)  state_nx = ST_EXIT;
            ST_EXIT:   if (tmr_done) state_nx = ST_ACCESS;
            ST_ACCESS: if (acc_done) state_nx = ST_AWAKE;
            ST_DEEP:   if (wake_req) state_nx = ST_WAKE;
            ST_WAKE:   if (tmr_done) state_nx = ST_AWAKE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_e      = CMD_NOP;
        cmd_data   = '0;
        cke        = 1'b1;
        clk_en     = 1'b1;
        acc_gnt    = 1'b0;
        acc_err    = 1'b0;
        reinit_req = 1'b0;
        unique case (state)
            ST_AWAKE:  acc_gnt = acc_req;
            ST_EMR_WR: begin
                cmd_e    = CMD_EMR;
                cmd_data = act_pasr;
            end
            ST_ENTER: begin
                cke = 1'b0;
                unique case (act_mode)
                    LPM_SREF:  cmd_e = CMD_SREF;
                    LPM_PDOWN: cmd_e = CMD_PDOWN;
                    LPM_DEEP:  cmd_e = CMD_DEEP;
                    LPM_OFF:   cmd_e = CMD_NOP;
                endcase
            end
            ST_ASLEEP: begin
                cke    = 1'b0;
                clk_en = !((act_mode == LPM_SREF) || act_freeze);
            end
            ST_EXIT: begin
                if (tmr_first) cmd_e = CMD_EXIT;
                acc_gnt = tmr_done;
            end
            ST_ACCESS: ;
            ST_DEEP: begin
                cke     = 1'b0;
                clk_en  = 1'b0;
                acc_err = acc_req;
            end
            ST_WAKE: begin
                if (tmr_first) cmd_e = CMD_EXIT;
                reinit_req = tmr_done;
            end
        endcase
    end

    assign cmd_valid = (cmd_e != CMD_NOP);
    assign cmd_code  = cmd_e;
endmodule

// File: rtl/sdram_lp_seq_chk.sv
module sdram_lp_seq_chk
    import sdram_lp_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input lp_state_e state,
    input lp_mode_e  act_mode,
    input logic [1:0] cfg_mode,
    input logic      cmd_valid,
    input logic [2:0] cmd_code,
    input logic      cke,
    input logic      clk_en,
    input logic      acc_gnt,
    input logic      acc_err
);
    a_r8_no_gnt_with_err: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_gnt && acc_err));

    a_r5_gnt_needs_cke: assert property (@(posedge clk) disable iff (!rst_n)
        acc_gnt |-> cke);

    a_r3_sref_drops_cke: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd1) |=> (!cke && !clk_en));

    a_r7_emr_then_sref: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd5) |=> (cmd_valid && cmd_code == 3'd1));

    a_r8_deep_stops_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd3) |=> (!cke && !clk_en));

    a_r2_off_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AWAKE && cfg_mode == 2'd0) |=> !cmd_valid);

    a_r10_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_AWAKE) |=> $stable(act_mode));
endmodule

bind sdram_lp_seq sdram_lp_seq_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .act_mode  (act_mode),
    .cfg_mode  (cfg_mode),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cke       (cke),
    .clk_en    (clk_en),
    .acc_gnt   (acc_gnt),
    .acc_err   (acc_err)
);

// File: tb/test_sdram_lp_seq.sv
`timescale 1ns/1ps
module test_sdram_lp_seq;
    localparam int PASR_W = 3;
    localparam int LAT_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cfg_mode = '0;
    logic              cfg_clk_freeze = 1'b0;
    logic [PASR_W-1:0] cfg_pasr = '0;
    logic [LAT_W-1:0]  cfg_exit_lat = '0;
    logic              init_done = 1'b0;
    logic              acc_req = 1'b0;
    logic              acc_done = 1'b0;
    logic              wake_req = 1'b0;
    logic              acc_gnt, acc_err, cmd_valid, cke, clk_en, reinit_req;
    logic [2:0]        cmd_code;
    logic [PASR_W-1:0] cmd_data;

    int errs = 0;
    int chks = 0;
    bit ended = 0;

    always #4 clk = ~clk;

    sdram_lp_seq #(.PASR_W(PASR_W), .LAT_W(LAT_W)) i_sdram_lp_seq (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
        .cfg_clk_freeze(cfg_clk_freeze), .cfg_pasr(cfg_pasr),
        .cfg_exit_lat(cfg_exit_lat), .init_done(init_done),
        .acc_req(acc_req), .acc_done(acc_done), .wake_req(wake_req),
        .acc_gnt(acc_gnt), .acc_err(acc_err), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_data(cmd_data), .cke(cke),
        .clk_en(clk_en), .reinit_req(reinit_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        chks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // negedges until first command (-1 if none within 20)
    task automatic wait_cmd(output int n, output int code, output int data);
        n = -1; code = 0; data = 0;
        for (int i = 1; i <= 20 && n < 0; i++) begin
            @(negedge clk);
            if (cmd_valid) begin
                n = i; code = int'(cmd_code); data = int'(cmd_data);
            end
        end
    endtask

    // request; n = cycles to grant, c1 = command seen in first cycle
    task automatic do_access(output int n, output int c1, output int k1);
        n = -1; c1 = 0; k1 = 0;
        acc_req = 1'b1;
        #1;
        if (acc_gnt) begin
            n = 0;
            @(negedge clk);
            acc_req = 1'b0;
        end else begin
            for (int i = 1; i <= 30 && n < 0; i++) begin
                @(negedge clk);
                if (i == 1) begin
                    c1 = cmd_valid ? int'(cmd_code) : 0;
                    k1 = int'(cke);
                end
                if (acc_gnt) n = i;
            end
            acc_req = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic finish_access();
        acc_done = 1'b1;
        @(negedge clk);
        acc_done = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!ended) begin
            errs++; chks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errs, chks);
            $finish;
        end
    end

    initial begin
        int n, c, d, k, last_pasr, expc;
        last_pasr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(cke && clk_en && !cmd_valid && !acc_gnt && !acc_err && !reinit_req,
            "R1 reset outputs", {cke, clk_en, cmd_valid, acc_gnt, acc_err, reinit_req}, 6'b110000);

        // R11: not initialized
        cfg_mode = 2'd2;
        wait_cmd(n, c, d);
        chk(n == -1, "R11 no entry before init", n, -1);
        chk(cke == 1'b1, "R11 cke high", int'(cke), 1);
        cfg_mode = 2'd0;
        init_done = 1'b1;

        // R2: mode off
        wait_cmd(n, c, d);
        chk(n == -1, "R2 no command in off mode", n, -1);
        do_access(n, c, k);
        chk(n == 0, "R2 immediate grant", n, 0);
        finish_access();
        chk(cke == 1'b1, "R2 cke high", int'(cke), 1);

        // sweep
        for (int m = 1; m <= 2; m++) begin
            for (int f = 0; f <= 1; f++) begin
                for (int l = 0; l <= 3; l++) begin
                    int p;
                    bit emr;
                    p = (l / 2) * 2 + f;
                    emr = (m == 1) && (p != last_pasr);
                    cfg_pasr = PASR_W'(p);
                    cfg_clk_freeze = f[0];
                    cfg_exit_lat = LAT_W'(l);
                    cfg_mode = 2'(m);
                    wait_cmd(n, c, d);
                    chk(n == 1, "R3 entry one cycle after awake", n, 1);
                    if (emr) begin
                        chk(c == 5 && d == p, "R7 extended write with value", c * 8 + d, 5 * 8 + p);
                        last_pasr = p;
                        wait_cmd(n, c, d);
                        chk(n == 1 && c == 1, "R7 self refresh follows write", n * 8 + c, 9);
                    end else begin
                        expc = (m == 1) ? 1 : 2;
                        chk(c == expc, "R4 entry code (R3 for mode 1)", c, expc);
                    end
                    @(negedge clk);
                    chk(cke == 1'b0, "R3 cke low asleep", int'(cke), 0);
                    expc = (m == 1 || f == 1) ? 0 : 1;
                    chk(int'(clk_en) == expc, "R4 clock enable asleep", int'(clk_en), expc);
                    do_access(n, c, k);
                    chk(c == 4 && k == 1, "R5 exit command with cke high", c * 2 + k, 9);
                    chk(n == l + 1, "R5 grant delay", n, l + 1);
                    finish_access();
                    wait_cmd(n, c, d);
                    expc = (m == 1) ? 1 : 2;
                    chk(n == 1 && c == expc, "R6 re-entry after access", n * 8 + c, 8 + expc);
                    @(negedge clk);
                    cfg_mode = 2'd0;
                    repeat (3) @(negedge clk);
                    chk(cke == 1'b0 && !cmd_valid, "R10 mode change held while asleep",
                        int'(cke), 0);
                    do_access(n, c, k);
                    chk(n == l + 1, "R5 grant delay second exit", n, l + 1);
                    finish_access();
                    wait_cmd(n, c, d);
                    chk(n == -1, "R10 off mode applied once awake", n, -1);
                    chk(cke == 1'b1, "R2 cke high after return", int'(cke), 1);
                end
            end
        end

        // R8: deep power-down
        cfg_exit_lat = LAT_W'(2);
        cfg_mode = 2'd3;
        wait_cmd(n, c, d);
        chk(n == 1 && c == 3, "R8 deep entry code", n * 8 + c, 11);
        @(negedge clk);
        chk(!cke && !clk_en, "R8 cke and clock off", {cke, clk_en}, 0);
        acc_req = 1'b1;
        #1;
        chk(acc_err && !acc_gnt, "R8 request refused", {acc_err, acc_gnt}, 2);
        repeat (3) begin
            @(negedge clk);
            chk(!acc_gnt && !cke, "R8 no grant in deep", int'(acc_gnt), 0);
        end
        acc_req = 1'b0;
        init_done = 1'b0;
        cfg_mode = 2'd0;
        // R9: wake
        wake_req = 1'b1;
        n = -1;
        for (int i = 1; i <= 10 && n < 0; i++) begin
            @(negedge clk);
            if (i == 1) begin
                wake_req = 1'b0;
                chk(cmd_valid && cmd_code == 3'd4 && cke, "R9 exit command on wake",
                    int'(cmd_code), 4);
            end
            if (reinit_req) n = i;
        end
        chk(n == 3, "R9 reinit pulse delay", n, 3);
        last_pasr = 0;
        wait_cmd(n, c, d);
        chk(n == -1 && cke, "R9 back awake, idle", n, -1);
        // R9/R7: recorded value cleared
        init_done = 1'b1;
        cfg_pasr = PASR_W'(3);
        cfg_mode = 2'd1;
        wait_cmd(n, c, d);
        chk(n == 1 && c == 5 && d == 3, "R9 partial-array record cleared",
            c * 8 + d, 5 * 8 + 3);

        ended = 1;
        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    end
endmodule